// File: doc/BRIEF.md
# Serial Configuration Register Slave

This block is a four-register configuration and status slave reached over a four-wire serial port (SPI mode 0: clock idles low, data sampled on the rising clock edge). A master pulls the active-low select low, sends a command bit and a seven-bit register address, and then either sends a data byte (write) or receives one (read). Three registers hold control fields that drive parallel outputs into neighbouring logic. The fourth register is read-only and reports a five-bit cable-length measurement. A live carrier-present flag also appears in the top bit of the first register.

The serial pins are sampled in the system clock domain. Each one passes through a two-stage synchroniser, and the serial clock and select are then edge-detected. The serial clock must therefore be slow against the system clock: each high and each low phase must last at least four system clocks. The read data line has its own output-enable, so several slaves can share it. The enable is raised only while the block is shifting out read data.

Top module: `spi_cfg_regfile`

## Requirements
- R1: A frame whose first bit is 0 is a write. Seven address bits follow, then eight data bits, all most significant bit first and sampled on rising serial-clock edges. The addressed register takes the data only once the sixteenth bit has been received.
- R2: A frame whose first bit is 1 is a read. The register named by the seven address bits is captured after the eighth rising edge. Its bits are presented on `misoOut` from bit 7 down to bit 0. The first bit appears after the eighth falling edge, and each later falling edge moves on to the next bit.
- R3: `misoOe` is 0 after reset, while select is high, during every write frame, and during a read frame before its eighth falling edge. From the eighth falling edge of a read it stays 1 until select returns high. While `misoOe` is 0, `misoOut` is 0.
- R4: A frame in which select returns high before the sixteenth bit writes nothing. The next frame starts only on a new falling edge of select.
- R5: After reset, `cfg0Out` is 08h (sleep code 01 in bits 4:3), `cfg1Out` is 64h (swing code 011 in bits 7:5, offset code 001 in bits 4:2) and `cfg2Out` is 00h.
- R6: Register 00h: bit 6 (mute), bits 4:3 (sleep code) and bit 2 (extended reach) are writable. Bit 7 reads the live `carrierIn` level, captured at the moment of the read, and is never stored. Bits 5, 1 and 0 read as 0 and appear as 0 on `cfg0Out`.
- R7: Register 01h stores bits 7:2, and bits 1:0 read as 0. Register 02h stores bits 7:3 (coarse bit 7, fine bits 6:3), and bits 2:0 read as 0. `cfg1Out` and `cfg2Out` show the same values.
- R8: Register 03h is read-only. It returns `cableLen` in bits 7:3 and zeros in bits 2:0, and a write to it changes nothing.
- R9: Addresses 04h to 7Fh read as 00h, and writes to them change nothing. All seven address bits are decoded, so 41h does not alias 01h.
- R10: Serial-clock edges after the sixteenth bit of a write, and before select rises, cause no further write and do not enable `misoOe`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sckIn | input | 1 | Serial clock from master, idles low |
| ssN | input | 1 | Active-low frame select |
| mosiIn | input | 1 | Serial data from master |
| misoOut | output | 1 | Serial read data to master |
| misoOe | output | 1 | Output enable for the read data driver |
| carrierIn | input | 1 | Live carrier-present status, 1 = present |
| cableLen | input | 5 | Cable-length measurement, 0 to 25 |
| cfg0Out | output | 8 | General control fields (register 00h, bit 7 reads 0) |
| cfg1Out | output | 8 | Output driver fields (register 01h) |
| cfg2Out | output | 8 | Input launch fields (register 02h) |

## Verification
A wrong frame phase (the bit counter off by one, or the command bit taken from the wrong position) shows at once as a misplaced `misoOe` rise or a register byte shifted by one bit. The bench sees this in the first read or write after the fault. If the state machine fails to return to idle when select rises, the next frame is framed wrongly, so an aborted or overlong frame is followed by a read that checks the framing. Wrong address decode or wrong field masks show on the `cfg*Out` ports as soon as the frame commits, a few system clocks after the sixteenth rising edge, and again on the next read-back.

// File: rtl/spi_cfg_pkg.sv
package spi_cfg_pkg;

  localparam int DATA_W = 8;

  // Register addresses (low bits of the 7-bit address field)
  localparam int ADDR_GEN    = 0;
  localparam int ADDR_DRV    = 1;
  localparam int ADDR_LAUNCH = 2;
  localparam int ADDR_CLEN   = 3;

  // Strobes from the frame control to the datapath
  typedef struct packed {
    logic shiftIn;    // take one MOSI bit into the receive shifter
    logic loadRead;   // capture the addressed register for readout
    logic misoShift;  // advance readout to the next bit
    logic commit;     // store the received data byte
  } ctrlStrb_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HDR,
    ST_RARM,
    ST_RDATA,
    ST_WDATA,
    ST_WCOMMIT,
    ST_DONE
  } frameSt_t;

endpackage

// File: rtl/spi_cfg_sync.sv
module spi_cfg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sckIn,
  input  logic ssN,
  input  logic mosiIn,
  output logic sckRise,
  output logic sckFall,
  output logic ssFall,
  output logic ssHigh,
  output logic mosiSync
);
  localparam int NSIG = 3;
  // reset levels: sck low, select high (inactive), mosi low
  localparam logic [NSIG-1:0] RST_VAL = 3'b010;

  logic [NSIG-1:0] raw;
  logic [NSIG-1:0] cur;
  logic [NSIG-1:0] prev;

  assign raw = {sckIn, ssN, mosiIn};

  for (genvar g = 0; g < NSIG; g++) begin : gSig
    logic [STAGES:0] chain;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain <= {(STAGES+1){RST_VAL[g]}};
      else       chain <= {chain[STAGES-1:0], raw[g]};
    end
    assign cur[g]  = chain[STAGES-1];
    assign prev[g] = chain[STAGES];
  end

  assign sckRise  =  cur[2] & ~prev[2];
  assign sckFall  = ~cur[2] &  prev[2];
  assign ssFall   = ~cur[1] &  prev[1];
  assign ssHigh   =  cur[1];
  assign mosiSync =  cur[0];
endmodule

// File: rtl/spi_cfg_ctrl.sv
module spi_cfg_ctrl
  import spi_cfg_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      sckRise,
  input  logic      sckFall,
  input  logic      ssFall,
  input  logic      ssHigh,
  input  logic      mosiSync,
  output ctrlStrb_t strb,
  output logic      misoOe
);
  localparam int HDR_BITS   = 1 + ADDR_W;
  localparam int FRAME_BITS = HDR_BITS + DATA_W;
  localparam int CNT_W      = $clog2(FRAME_BITS + 1);
  localparam int OUT_W      = $clog2(DATA_W);

  frameSt_t         state;
  logic [CNT_W-1:0] bitCnt;
  logic [OUT_W-1:0] outCnt;
  logic             isRead;

  always_comb begin
    strb           = '0;
    strb.shiftIn   = sckRise && (state == ST_HDR || state == ST_WDATA);
    strb.loadRead  = (state == ST_RARM);
    strb.misoShift = sckFall && (state == ST_RDATA) && misoOe
                     && (outCnt < OUT_W'(DATA_W - 1));
    strb.commit    = (state == ST_WCOMMIT);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
      outCnt <= '0;
      isRead <= 1'b0;
      misoOe <= 1'b0;
    end else if (ssHigh) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
      outCnt <= '0;
      misoOe <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (ssFall) begin
            state  <= ST_HDR;
            bitCnt <= '0;
          end
        end
        ST_HDR: begin
          if (sckRise) begin
            bitCnt <= bitCnt + 1'b1;
            if (bitCnt == '0) isRead <= mosiSync;
            if (bitCnt == CNT_W'(HDR_BITS - 1))
              state <= isRead ? ST_RARM : ST_WDATA;
          end
        end
        ST_RARM: begin
          state  <= ST_RDATA;
          outCnt <= '0;
        end
        ST_RDATA: begin
          if (sckFall) begin
            if (!misoOe) misoOe <= 1'b1;
            else if (outCnt < OUT_W'(DATA_W - 1)) outCnt <= outCnt + 1'b1;
          end
        end
        ST_WDATA: begin
          if (sckRise) begin
            bitCnt <= bitCnt + 1'b1;
            if (bitCnt == CNT_W'(FRAME_BITS - 1)) state <= ST_WCOMMIT;
          end
        end
        ST_WCOMMIT: state <= ST_DONE;
        default:    state <= state;
      endcase
    end
  end
endmodule

// File: rtl/spi_cfg_dp.sv
module spi_cfg_dp
  import spi_cfg_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int CLW    = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrb_t         strb,
  input  logic              mosiSync,
  input  logic              carrierIn,
  input  logic [CLW-1:0]    cableLen,
  output logic [DATA_W-1:0] cfg0Out,
  output logic [DATA_W-1:0] cfg1Out,
  output logic [DATA_W-1:0] cfg2Out,
  output logic              misoBit
);
  localparam int SH_W = ADDR_W + DATA_W;

  logic [SH_W-1:0]   rxShift;
  logic [DATA_W-1:0] txShift;
  logic [DATA_W-1:0] rdByte;
  logic [ADDR_W-1:0] wAddr;
  logic [DATA_W-1:0] wData;

  // stored fields
  logic       genMute;
  logic [1:0] genSleep;
  logic       genExt;
  logic [2:0] drvSwing;
  logic [2:0] drvOffset;
  logic       lnCoarse;
  logic [3:0] lnFine;

  assign wAddr = rxShift[SH_W-1:DATA_W];
  assign wData = rxShift[DATA_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rxShift <= '0;
    else if (strb.shiftIn) rxShift <= {rxShift[SH_W-2:0], mosiSync};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      genMute   <= 1'b0;
      genSleep  <= 2'b01;
      genExt    <= 1'b0;
      drvSwing  <= 3'b011;
      drvOffset <= 3'b001;
      lnCoarse  <= 1'b0;
      lnFine    <= 4'b0000;
    end else if (strb.commit) begin
      case (wAddr)
        ADDR_W'(ADDR_GEN): begin
          genMute  <= wData[6];
          genSleep <= wData[4:3];
          genExt   <= wData[2];
        end
        ADDR_W'(ADDR_DRV): begin
          drvSwing  <= wData[7:5];
          drvOffset <= wData[4:2];
        end
        ADDR_W'(ADDR_LAUNCH): begin
          lnCoarse <= wData[7];
          lnFine   <= wData[6:3];
        end
        default: ;
      endcase
    end
  end

  assign cfg0Out = {1'b0, genMute, 1'b0, genSleep, genExt, 2'b00};
  assign cfg1Out = {drvSwing, drvOffset, 2'b00};
  assign cfg2Out = {lnCoarse, lnFine, 3'b000};

  always_comb begin
    case (rxShift[ADDR_W-1:0])
      ADDR_W'(ADDR_GEN):    rdByte = cfg0Out | {carrierIn, {(DATA_W-1){1'b0}}};
      ADDR_W'(ADDR_DRV):    rdByte = cfg1Out;
      ADDR_W'(ADDR_LAUNCH): rdByte = cfg2Out;
      ADDR_W'(ADDR_CLEN):   rdByte = {cableLen, {(DATA_W-CLW){1'b0}}};
      default:              rdByte = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) txShift <= '0;
    else if (strb.loadRead) txShift <= rdByte;
    else if (strb.misoShift) txShift <= {txShift[DATA_W-2:0], 1'b0};
  end

  assign misoBit = txShift[DATA_W-1];
endmodule

// File: rtl/spi_cfg_regfile.sv
module spi_cfg_regfile
  import spi_cfg_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int CLW         = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sckIn,
  input  logic              ssN,
  input  logic              mosiIn,
  output logic              misoOut,
  output logic              misoOe,
  input  logic              carrierIn,
  input  logic [CLW-1:0]    cableLen,
  output logic [DATA_W-1:0] cfg0Out,
  output logic [DATA_W-1:0] cfg1Out,
  output logic [DATA_W-1:0] cfg2Out
);
  logic      sckRise, sckFall, ssFall, ssHigh, mosiSync;
  logic      misoBit;
  ctrlStrb_t strb;

  spi_cfg_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .sckIn(sckIn), .ssN(ssN), .mosiIn(mosiIn),
    .sckRise(sckRise), .sckFall(sckFall), .ssFall(ssFall),
    .ssHigh(ssHigh), .mosiSync(mosiSync)
  );

  spi_cfg_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .sckRise(sckRise), .sckFall(sckFall),
    .ssFall(ssFall), .ssHigh(ssHigh), .mosiSync(mosiSync),
    .strb(strb), .misoOe(misoOe)
  );

  spi_cfg_dp #(.ADDR_W(ADDR_W), .CLW(CLW)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .mosiSync(mosiSync),
    .carrierIn(carrierIn), .cableLen(cableLen),
    .cfg0Out(cfg0Out), .cfg1Out(cfg1Out), .cfg2Out(cfg2Out),
    .misoBit(misoBit)
  );

  assign misoOut = misoOe & misoBit;
endmodule

// File: rtl/spi_cfg_chk.sv
module spi_cfg_chk
  import spi_cfg_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              sckRise,
  input logic              ssFall,
  input logic              ssHigh,
  input ctrlStrb_t         strb,
  input logic              misoOe,
  input logic              misoOut,
  input logic [DATA_W-1:0] cfg0Out,
  input logic [DATA_W-1:0] cfg1Out,
  input logic [DATA_W-1:0] cfg2Out
);
  // independent count of rising serial-clock edges within a frame
  logic [4:0] riseCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) riseCnt <= '0;
    else if (ssHigh || ssFall) riseCnt <= '0;
    else if (sckRise && riseCnt != 5'd31) riseCnt <= riseCnt + 1'b1;
  end

  a_r1_commit_at_16: assert property (@(posedge clk) disable iff (!rstN)
    strb.commit |-> riseCnt == 5'd16);

  a_r2_oe_rise_at_8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(misoOe) |-> riseCnt == 5'd8);

  a_r3_oe_drop_ss_high: assert property (@(posedge clk) disable iff (!rstN)
    ssHigh |=> !misoOe);

  a_r3_quiet_when_off: assert property (@(posedge clk) disable iff (!rstN)
    !misoOe |-> !misoOut);

  a_r10_no_oe_on_write: assert property (@(posedge clk) disable iff (!rstN)
    strb.commit |-> !misoOe);

  a_r4_cfg_stable_no_commit: assert property (@(posedge clk) disable iff (!rstN)
    !strb.commit |=> $stable({cfg0Out, cfg1Out, cfg2Out}));

  a_r7_reserved_zero: assert property (@(posedge clk) disable iff (!rstN)
    cfg1Out[1:0] == 2'b00 && cfg2Out[2:0] == 3'b000);

  a_r6_reserved_zero: assert property (@(posedge clk) disable iff (!rstN)
    cfg0Out[7] == 1'b0 && cfg0Out[5] == 1'b0 && cfg0Out[1:0] == 2'b00);
endmodule

bind spi_cfg_regfile spi_cfg_chk u_chk (
  .clk(clk), .rstN(rstN), .sckRise(sckRise), .ssFall(ssFall),
  .ssHigh(ssHigh), .strb(strb), .misoOe(misoOe), .misoOut(misoOut),
  .cfg0Out(cfg0Out), .cfg1Out(cfg1Out), .cfg2Out(cfg2Out)
);

// File: tb/spi_cfg_regfile_tb.sv
module spi_cfg_regfile_tb;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sckIn = 1'b0, ssN = 1'b1, mosiIn = 1'b0;
  logic carrierIn = 1'b0;
  logic [4:0] cableLen = 5'd0;
  logic misoOut, misoOe;
  logic [7:0] cfg0Out, cfg1Out, cfg2Out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [7:0] expQ[$];
  string      tagQ[$];
  logic [7:0] capByte;
  event       capEv;

  always #2 clk = ~clk;

  spi_cfg_regfile u_dut (
    .clk(clk), .rstN(rstN), .sckIn(sckIn), .ssN(ssN), .mosiIn(mosiIn),
    .misoOut(misoOut), .misoOe(misoOe), .carrierIn(carrierIn),
    .cableLen(cableLen), .cfg0Out(cfg0Out), .cfg1Out(cfg1Out),
    .cfg2Out(cfg2Out)
  );

  task automatic chk(input string req, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Drives nBits of word, MSB first; records misoOe before each rise and
  // captures MISO for positions 8..15.
  task automatic xfer(input logic [23:0] word, input int nBits,
                      output logic [23:0] oeMask, output logic [7:0] got);
    oeMask = '0;
    got = '0;
    @(negedge clk);
    ssN = 1'b0;
    waitClk(HALF);
    for (int i = 0; i < nBits; i++) begin
      mosiIn = word[23-i];
      waitClk(HALF);
      oeMask[23-i] = misoOe;
      if (i >= 8 && i < 16) got[15-i] = misoOut;
      sckIn = 1'b1;
      waitClk(HALF);
      sckIn = 1'b0;
    end
    waitClk(HALF);
    ssN = 1'b1;
    waitClk(HALF);
  endtask

  task automatic spiWrite(input logic [6:0] addr, input logic [7:0] data, input string req);
    logic [23:0] m; logic [7:0] g;
    xfer({1'b0, addr, data, 8'h00}, 16, m, g);
    chk({req, " oe off in write"}, m, 24'h0);
  endtask

  task automatic spiRead(input logic [6:0] addr, input logic [7:0] expv, input string req);
    logic [23:0] m; logic [7:0] g;
    expQ.push_back(expv);
    tagQ.push_back(req);
    xfer({1'b1, addr, 16'h0000}, 16, m, g);
    chk("R3 oe window in read", m, 24'h00FF00);
    chk("R3 oe off after select high", {23'd0, misoOe}, 24'd0);
    capByte = g;
    ->capEv;
    waitClk(1);
  endtask

  // monitor: compares each captured read byte against the scoreboard
  initial begin
    forever begin
      @capEv;
      if (expQ.size() == 0) begin
        chk("R2 unexpected read", {16'd0, capByte}, 24'hFFFFFF);
      end else begin
        logic [7:0] e; string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        chk(t, {16'd0, capByte}, {16'd0, e});
      end
    end
  end

  initial begin
    logic [23:0] m; logic [7:0] g;
    waitClk(5);
    rstN = 1'b1;
    waitClk(5);
    // R5 reset state
    chk("R5 cfg0 reset", {16'd0, cfg0Out}, 24'h08);
    chk("R5 cfg1 reset", {16'd0, cfg1Out}, 24'h64);
    chk("R5 cfg2 reset", {16'd0, cfg2Out}, 24'h00);
    chk("R3 oe reset", {23'd0, misoOe}, 24'd0);

    spiRead(7'h01, 8'h64, "R2 R5 read reg01 reset");
    spiRead(7'h00, 8'h08, "R6 read reg00 reset, carrier 0");

    // R1 MSB-first write
    spiWrite(7'h01, 8'hA4, "R1");
    chk("R1 cfg1 after write", {16'd0, cfg1Out}, 24'hA4);
    spiRead(7'h01, 8'hA4, "R1 R2 readback reg01");

    // R7 masks
    spiWrite(7'h01, 8'hFF, "R7");
    chk("R7 cfg1 masked", {16'd0, cfg1Out}, 24'hFC);
    spiWrite(7'h02, 8'hFF, "R7");
    chk("R7 cfg2 masked", {16'd0, cfg2Out}, 24'hF8);
    spiRead(7'h02, 8'hF8, "R7 readback reg02");

    // R6 general control
    spiWrite(7'h00, 8'hFF, "R6");
    chk("R6 cfg0 masked", {16'd0, cfg0Out}, 24'h5C);
    carrierIn = 1'b1;
    spiRead(7'h00, 8'hDC, "R6 read reg00 carrier 1");
    carrierIn = 1'b0;
    spiRead(7'h00, 8'h5C, "R6 read reg00 carrier 0");

    // R8 read-only cable length
    cableLen = 5'd25;
    spiRead(7'h03, 8'hC8, "R8 read cable length 25");
    spiWrite(7'h03, 8'hFF, "R8");
    chk("R8 write ignored", {cfg0Out, cfg1Out, cfg2Out}, 24'h5CFCF8);
    spiRead(7'h03, 8'hC8, "R8 read after write");
    cableLen = 5'd0;
    spiRead(7'h03, 8'h00, "R8 read cable length 0");

    // R9 unimplemented addresses, full decode
    spiRead(7'h45, 8'h00, "R9 read unimplemented");
    spiWrite(7'h41, 8'h00, "R9");
    spiWrite(7'h7F, 8'h00, "R9");
    chk("R9 write ignored", {cfg0Out, cfg1Out, cfg2Out}, 24'h5CFCF8);
    spiRead(7'h41, 8'h00, "R9 read alias address");

    // R4 aborted frames
    xfer({1'b0, 7'h02, 8'h00, 8'h00}, 12, m, g);
    chk("R4 12-bit frame ignored", {16'd0, cfg2Out}, 24'hF8);
    xfer({1'b0, 7'h02, 8'h00, 8'h00}, 15, m, g);
    chk("R4 15-bit frame ignored", {16'd0, cfg2Out}, 24'hF8);
    spiRead(7'h02, 8'hF8, "R4 framing after abort");

    // R10 extra clocks after a write
    xfer({1'b0, 7'h01, 8'h48, 8'hFF}, 24, m, g);
    chk("R10 single commit", {16'd0, cfg1Out}, 24'h48);
    chk("R10 oe stays off", m, 24'h0);
    spiRead(7'h01, 8'h48, "R10 readback after long frame");

    waitClk(20);
    chk("R2 all reads consumed", {16'd0, 8'(expQ.size())}, 24'd0);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule